// File: doc/BRIEF.md
# Fixed Memory Map Region Decoder

This block classifies every access of the main processor's flat 16-bit address space into a region code. It also produces a byte offset relative to that region's base. The regions are main RAM, switchable ROM or alternate RAM, work RAM, shared RAM, memory-mapped I/O, two boot images, boot RAM, the interrupt vector area, the reset vector and an initiator ROM overlay. The selection follows live mode bits: ROM enable, a two-bit boot mode, the overlay enable and the halt state of the sub-processor.

The decode is registered. A request presented on one clock edge appears on the outputs, with its region and offset, one cycle later. At the same time the block turns the request into gated read and write strobes for the memory behind the selected region.

The block masks any region that cannot be reached at that moment. Shared RAM and the null region return 0xFF and drop writes. Writes to ROM, boot images and the overlay are dropped. Writes to boot RAM are dropped unless boot-RAM write enable is set. The reset vector bytes are produced inside the block, so the memory is never strobed for them. The memories and any paged address translation sit outside the block.

Top module: `mm_region_decoder`

## Requirements
- R1: With the overlay disabled, addresses 0x0000-0x7FFF give region code 0 (main RAM), offset equal to the address, and are readable and writable.
- R2: Addresses 0x8000-0xFBFF give offset address-0x8000. With ROM enable set they give region code 1 (ROM), whose writes are discarded. With ROM enable clear they give region code 2 (alternate RAM), which is writable.
- R3: 0xFC00-0xFC7F gives code 3 (work RAM), 0xFC80-0xFCFF gives code 4 (shared RAM) and 0xFD00-0xFDFF gives code 5 (I/O). Each offset is measured from its own region's first address.
- R4: While the sub-processor is not halted, shared RAM reads return 0xFF without a memory read strobe and its writes are discarded. While it is halted, shared RAM reads and writes pass through.
- R5: 0xFE00-0xFFDF gives offset address-0xFE00, and the region comes from the boot mode. Mode 0 gives code 6 (boot image A), mode 1 gives code 7 (boot image B), mode 2 gives code 8 (boot RAM) and mode 3 gives code 15 (null). Boot images are read-only.
- R6: Writes to boot RAM reach the memory only when boot-RAM write enable is set; otherwise they are discarded.
- R7: 0xFFE0-0xFFFD gives code 9 (vector area, writable) with offset address-0xFFE0. 0xFFFE-0xFFFF gives code 10 (reset vector) with offset address-0xFFFE, reads 0xFE at offset 0 and 0x00 at offset 1, and never strobes the memory.
- R8: With the overlay enabled, 0x6000-0x7FFF gives code 11 (initiator ROM) with offset address-0x6000, and writes there are discarded. Main RAM below 0x6000 is unaffected.
- R9: The null region (code 15) reads as 0xFF, raises no strobe and discards writes.
- R10: Outputs follow a request after exactly one clock. After reset, and in any cycle following one with no request, out_valid, out_rd and out_wr are low. After reset the region reads code 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Untranslated address |
| rom_en | input | 1 | Upper area maps ROM instead of alternate RAM |
| boot_mode | input | 2 | Boot area selection |
| init_ovl_en | input | 1 | Initiator ROM overlay enable |
| bootram_wr_en | input | 1 | Boot RAM write enable |
| sub_halted | input | 1 | Sub-processor is halted |
| mem_rdata | input | 8 | Data from the selected memory |
| out_valid | output | 1 | Decoded access is presented |
| out_region | output | 4 | Region code |
| out_offset | output | 15 | Region-relative offset |
| out_rd | output | 1 | Gated memory read strobe |
| out_wr | output | 1 | Gated memory write strobe |
| rd_data | output | 8 | Read data after masking and vector insertion |

## Verification
A wrong decode register appears in the next cycle as a wrong region code or offset for the access that was just issued. The bench compares both against values computed from the address map, at every region boundary. A wrong held access flag appears in that same cycle as a write strobe that should have been dropped, or as a pass-through where 0xFF was expected. The bench checks this for shared RAM with the sub-processor both running and halted, for boot RAM with its write enable both clear and set, and for the read-only regions. A stale valid flag would leave strobes high in the cycle after a request, and an idle-cycle check catches that.

// File: rtl/mm_region_pkg.sv
package mm_region_pkg;

    localparam int ADDR_W = 16;
    localparam int OFF_W  = ADDR_W - 1;
    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        RG_MAIN    = 4'd0,
        RG_ROM     = 4'd1,
        RG_ALT     = 4'd2,
        RG_WORK    = 4'd3,
        RG_SHARED  = 4'd4,
        RG_IO      = 4'd5,
        RG_BOOT_A  = 4'd6,
        RG_BOOT_B  = 4'd7,
        RG_BOOTRAM = 4'd8,
        RG_VECTOR  = 4'd9,
        RG_RESET   = 4'd10,
        RG_INIT    = 4'd11,
        RG_NULL    = 4'd15
    } region_t;

    localparam logic [ADDR_W-1:0] BASE_UPPER  = 16'h8000;
    localparam logic [ADDR_W-1:0] BASE_WORK   = 16'hFC00;
    localparam logic [ADDR_W-1:0] BASE_SHARED = 16'hFC80;
    localparam logic [ADDR_W-1:0] BASE_IO     = 16'hFD00;
    localparam logic [ADDR_W-1:0] BASE_BOOT   = 16'hFE00;
    localparam logic [ADDR_W-1:0] BASE_VECTOR = 16'hFFE0;
    localparam logic [ADDR_W-1:0] BASE_RESET  = 16'hFFFE;
    localparam logic [ADDR_W-1:0] BASE_INIT   = 16'h6000;
    localparam logic [ADDR_W-1:0] TOP_INIT    = 16'h7FFF;

endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode
    import mm_region_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    input  logic [1:0]        boot_mode,
    input  logic              init_ovl_en,
    output region_t           region,
    output logic [OFF_W-1:0]  offset
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        region = RG_NULL;
        base   = '0;
        if (addr < BASE_UPPER) begin
            if (init_ovl_en && addr >= BASE_INIT && addr <= TOP_INIT) begin
                region = RG_INIT;
                base   = BASE_INIT;
            end else begin
                region = RG_MAIN;
                base   = '0;
            end
        end else if (addr < BASE_WORK) begin
            region = rom_en ? RG_ROM : RG_ALT;
            base   = BASE_UPPER;
        end else if (addr < BASE_SHARED) begin
            region = RG_WORK;
            base   = BASE_WORK;
        end else if (addr < BASE_IO) begin
            region = RG_SHARED;
            base   = BASE_SHARED;
        end else if (addr < BASE_BOOT) begin
            region = RG_IO;
            base   = BASE_IO;
        end else if (addr < BASE_VECTOR) begin
            base = BASE_BOOT;
            unique case (boot_mode)
                2'd0:    region = RG_BOOT_A;
                2'd1:    region = RG_BOOT_B;
                2'd2:    region = RG_BOOTRAM;
                default: region = RG_NULL;
            endcase
        end else if (addr < BASE_RESET) begin
            region = RG_VECTOR;
            base   = BASE_VECTOR;
        end else begin
            region = RG_RESET;
            base   = BASE_RESET;
        end
    end

    assign diff   = addr - base;
    assign offset = diff[OFF_W-1:0];

endmodule

// File: rtl/mm_access_policy.sv
module mm_access_policy
    import mm_region_pkg::*;
(
    input  region_t region,
    input  logic    is_write,
    input  logic    sub_halted,
    input  logic    bootram_wr_en,
    output logic    allow_rd,
    output logic    allow_wr,
    output logic    force_ff
);

    logic writable;
    logic blocked;

    always_comb begin
        blocked = (region == RG_NULL) || (region == RG_SHARED && !sub_halted);
        unique case (region)
            RG_MAIN, RG_ALT, RG_WORK, RG_IO, RG_VECTOR: writable = 1'b1;
            RG_SHARED:  writable = sub_halted;
            RG_BOOTRAM: writable = bootram_wr_en;
            default:    writable = 1'b0;
        endcase
    end

    assign allow_wr = is_write && writable;
    assign allow_rd = !is_write && !blocked && (region != RG_RESET);
    assign force_ff = blocked;

endmodule

// File: rtl/mm_region_decoder.sv
module mm_region_decoder
    import mm_region_pkg::*;
#(
    parameter logic [15:0] RESET_VECTOR = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [15:0]       req_addr,
    input  logic              rom_en,
    input  logic [1:0]        boot_mode,
    input  logic              init_ovl_en,
    input  logic              bootram_wr_en,
    input  logic              sub_halted,
    input  logic [7:0]        mem_rdata,
    output logic              out_valid,
    output logic [3:0]        out_region,
    output logic [14:0]       out_offset,
    output logic              out_rd,
    output logic              out_wr,
    output logic [7:0]        rd_data
);

    region_t          dec_region;
    logic [OFF_W-1:0] dec_offset;
    logic             pol_rd, pol_wr, pol_ff;

    region_t          q_region;
    logic [OFF_W-1:0] q_offset;
    logic             q_valid, q_rd, q_wr, q_ff;

    mm_addr_decode u_dec (
        .addr        (req_addr),
        .rom_en      (rom_en),
        .boot_mode   (boot_mode),
        .init_ovl_en (init_ovl_en),
        .region      (dec_region),
        .offset      (dec_offset)
    );

    mm_access_policy u_pol (
        .region        (dec_region),
        .is_write      (req_write),
        .sub_halted    (sub_halted),
        .bootram_wr_en (bootram_wr_en),
        .allow_rd      (pol_rd),
        .allow_wr      (pol_wr),
        .force_ff      (pol_ff)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_region <= RG_NULL;
            q_offset <= '0;
            q_rd     <= 1'b0;
            q_wr     <= 1'b0;
            q_ff     <= 1'b1;
        end else begin
            q_valid <= req_valid;
            q_rd    <= req_valid && pol_rd;
            q_wr    <= req_valid && pol_wr;
            if (req_valid) begin
                q_region <= dec_region;
                q_offset <= dec_offset;
                q_ff     <= pol_ff;
            end
        end
    end

    logic [DATA_W-1:0] vec_byte;

    always_comb begin
        vec_byte = q_offset[0] ? RESET_VECTOR[7:0] : RESET_VECTOR[15:8];
        if (q_ff)
            rd_data = 8'hFF;
        else if (q_region == RG_RESET)
            rd_data = vec_byte;
        else
            rd_data = mem_rdata;
    end

    assign out_valid  = q_valid;
    assign out_region = q_region;
    assign out_offset = q_offset;
    assign out_rd     = q_rd;
    assign out_wr     = q_wr;

    // R1: main RAM passes the address unchanged one cycle later
    a_r1_main_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[15] && !init_ovl_en) |=>
            (out_region == 4'd0 && out_offset == $past(req_addr[14:0])));

    // R2: ROM never receives a write strobe
    a_r2_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_region == 4'd1) |-> !out_wr);

    // R4: shared RAM masked while the sub-processor runs
    a_r4_shared_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sub_halted && req_addr >= 16'hFC80 && req_addr < 16'hFD00) |=>
            (rd_data == 8'hFF && !out_wr && !out_rd));

    // R6: boot RAM write dropped when its enable is clear
    a_r6_bootram_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !bootram_wr_en && boot_mode == 2'd2 &&
         req_addr >= 16'hFE00 && req_addr < 16'hFFE0) |=> !out_wr);

    // R7: reset vector bytes come from inside the block
    a_r7_reset_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_region == 4'd10) |->
            (!out_rd && rd_data == (out_offset[0] ? 8'h00 : 8'hFE)));

    // R9: null region reads 0xFF and takes no strobe
    a_r9_null_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_region == 4'd15) |-> (rd_data == 8'hFF && !out_wr && !out_rd));

    // R10: no strobes in the cycle after an idle one
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_rd && !out_wr));

endmodule

// File: tb/sim_mm_region_decoder.sv
module sim_mm_region_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        rom_en = 1'b1;
    logic [1:0]  boot_mode = 2'd0;
    logic        init_ovl_en = 1'b0;
    logic        bootram_wr_en = 1'b0;
    logic        sub_halted = 1'b0;
    logic [7:0]  mem_rdata = 8'h5A;
    logic        out_valid, out_rd, out_wr;
    logic [3:0]  out_region;
    logic [14:0] out_offset;
    logic [7:0]  rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    mm_region_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .rom_en(rom_en), .boot_mode(boot_mode),
        .init_ovl_en(init_ovl_en), .bootram_wr_en(bootram_wr_en),
        .sub_halted(sub_halted), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_region(out_region), .out_offset(out_offset), .out_rd(out_rd),
        .out_wr(out_wr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // issue one access, leave outputs presented for sampling
    task automatic access(input logic [15:0] a, input logic w);
        @(negedge clk);
        req_addr  = a;
        req_write = w;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [15:0] a,
                             input int reg_exp, input int off_exp, input int data_exp,
                             input int rd_exp);
        access(a, 1'b0);
        check({tag, " region"}, out_region, reg_exp);
        check({tag, " offset"}, out_offset, off_exp);
        check({tag, " data"}, rd_data, data_exp);
        check({tag, " rd"}, out_rd, rd_exp);
        check({tag, " valid"}, out_valid, 1);
    endtask

    task automatic expect_wr(input string tag, input logic [15:0] a, input int wr_exp);
        access(a, 1'b1);
        check({tag, " wr"}, out_wr, wr_exp);
    endtask

    task automatic t_reset;
        check("R10 reset valid", out_valid, 0);
        check("R10 reset region", out_region, 15);
        check("R10 reset wr", out_wr, 0);
        check("R10 reset rd", out_rd, 0);
    endtask

    task automatic t_main;
        expect_rd("R1 main", 16'h1234, 0, 16'h1234, 8'h5A, 1);
        expect_rd("R1 main top", 16'h7FFF, 0, 16'h7FFF, 8'h5A, 1);
        expect_wr("R1 main write", 16'h0042, 1);
    endtask

    task automatic t_upper;
        rom_en = 1'b1;
        expect_rd("R2 rom", 16'h9000, 1, 16'h1000, 8'h5A, 1);
        expect_wr("R2 rom write", 16'h9000, 0);
        rom_en = 1'b0;
        expect_rd("R2 alt top", 16'hFBFF, 2, 16'h7BFF, 8'h5A, 1);
        expect_wr("R2 alt write", 16'h8000, 1);
        rom_en = 1'b1;
    endtask

    task automatic t_small;
        expect_rd("R3 work", 16'hFC00, 3, 0, 8'h5A, 1);
        expect_rd("R3 work end", 16'hFC7F, 3, 16'h7F, 8'h5A, 1);
        expect_rd("R3 io", 16'hFD03, 5, 3, 8'h5A, 1);
        sub_halted = 1'b1;
        expect_rd("R3 shared", 16'hFCA5, 4, 16'h25, 8'h5A, 1);
    endtask

    task automatic t_shared;
        sub_halted = 1'b0;
        expect_rd("R4 shared running", 16'hFC80, 4, 0, 8'hFF, 0);
        expect_wr("R4 shared write running", 16'hFC90, 0);
        sub_halted = 1'b1;
        expect_wr("R4 shared write halted", 16'hFC90, 1);
        sub_halted = 1'b0;
    endtask

    task automatic t_boot;
        boot_mode = 2'd0;
        expect_rd("R5 boot A", 16'hFE40, 6, 16'h40, 8'h5A, 1);
        expect_wr("R5 boot A write", 16'hFE40, 0);
        boot_mode = 2'd1;
        expect_rd("R5 boot B", 16'hFE00, 7, 0, 8'h5A, 1);
        boot_mode = 2'd2;
        expect_rd("R5 boot RAM end", 16'hFFDF, 8, 16'h1DF, 8'h5A, 1);
        boot_mode = 2'd3;
        expect_rd("R9 boot null", 16'hFE10, 15, 16'h10, 8'hFF, 0);
        expect_wr("R9 null write", 16'hFE10, 0);
        boot_mode = 2'd2;
        bootram_wr_en = 1'b0;
        expect_wr("R6 bootram locked", 16'hFE20, 0);
        bootram_wr_en = 1'b1;
        expect_wr("R6 bootram open", 16'hFE20, 1);
        bootram_wr_en = 1'b0;
        boot_mode = 2'd0;
    endtask

    task automatic t_vectors;
        expect_rd("R7 vector", 16'hFFE4, 9, 4, 8'h5A, 1);
        expect_wr("R7 vector write", 16'hFFFD, 1);
        expect_rd("R7 reset hi", 16'hFFFE, 10, 0, 8'hFE, 0);
        expect_rd("R7 reset lo", 16'hFFFF, 10, 1, 8'h00, 0);
        expect_wr("R7 reset write", 16'hFFFE, 0);
    endtask

    task automatic t_overlay;
        init_ovl_en = 1'b1;
        expect_rd("R8 overlay", 16'h6010, 11, 16'h10, 8'h5A, 1);
        expect_rd("R8 overlay end", 16'h7FFF, 11, 16'h1FFF, 8'h5A, 1);
        expect_wr("R8 overlay write", 16'h6000, 0);
        expect_rd("R8 below overlay", 16'h5FFF, 0, 16'h5FFF, 8'h5A, 1);
        init_ovl_en = 1'b0;
    endtask

    task automatic t_idle;
        access(16'h0100, 1'b1);
        @(negedge clk);
        check("R10 idle valid", out_valid, 0);
        check("R10 idle wr", out_wr, 0);
        check("R10 idle rd", out_rd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_main();
        t_upper();
        t_small();
        t_shared();
        t_boot();
        t_vectors();
        t_overlay();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule